// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

A programmable state machine that decides, sample by sample, when a capture engine has found the event of interest. It walks through a chain of sequence levels. Each level carries its own advance condition, branch condition with a destination level, occurrence count, store condition and timer actions. The conditions are built from recognizer match flags and the expiry flags of two general timers. On every qualified sample the sequencer reports whether that sample should be kept, and it emits a single trigger pulse once the last level has been satisfied.

Arming comes from a run request, from a partner sequencer, or from the rising edge of an external line. After the trigger the sequencer drops back to idle and waits for the next arm. In timing mode the chain is shorter and every sample taken while the sequencer is active is kept. In state mode the store condition of the current level selects which samples are kept.

Top module: `trig_seq`

## Requirements
- R1: After reset `active`, `trig` and `store_en` are 0 and `level` is 0.
- R2: From idle, a high `arm_run`, a high `arm_peer` or a 0-to-1 transition of `ext_arm` starts the sequencer at level 0 with a cleared occurrence count and both timers cleared and stopped. When one of these is seen, `active` is 1 after the next clock edge. A held-high `ext_arm` does not re-arm. All arm inputs are ignored while the sequencer is active.
- R3: A condition is 10 bits: op in [9:6], source A in [5:3], source B in [2:0]. Sources 0..5 are `flags[0..5]`, source 6 is the timer 0 expiry flag and source 7 is the timer 1 expiry flag. The ops are: 0 always, 1 never, 2 A, 3 not A, 4 A and B, 5 A nand B, 6 A or B, 7 A nor B, 8 A xor B, 9 A xnor B. Ops 10 to 15 evaluate as never.
- R4: The config word for level i is `cfg_levels[i*58 +: 58]`. Its fields are: advance condition [9:0], branch condition [19:10], store condition [29:20], branch target [33:30], occurrence count [53:34], timer actions [57:54]. A level is left through its advance condition only on the sample that brings its count of qualified samples to the programmed count, where a count of 0 acts as 1. The count restarts at 0 whenever a level is entered, including re-entry of the same level.
- R5: If the branch condition is true on a sample, the sequencer goes to the branch target and the advance condition is ignored. A target beyond the last level goes to the last level.
- R6: When the last level's count completes, `trig` is 1 for exactly one cycle, and after that same edge `active` is 0 and `level` is 0.
- R7: `store_en` is registered. After the edge that samples a strobe it is 1 when the sequencer was active and either `timing_mode` is 1 or the current level's store condition was true; otherwise it is 0.
- R8: The last level is `cfg_last`, limited to 11 in state mode and to 9 in timing mode.
- R9: Timer actions are set per level with 2 bits per timer (timer 0 in [55:54], timer 1 in [57:56]): 1 clears the timer and runs it, 2 pauses it, 3 continues it. The action applies on entry to any level except level 0. A running timer counts one per clock up to its limit in `tmr_limit` (timer t in bits [t*16 +: 16]). Its expiry flag is 1 when the count equals a nonzero limit. The trigger stops both timers.
- R10: With `strobe` low, the level, occurrence count and trigger do not change and `store_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_levels | input | 696 | Per-level configuration words, 58 bits each |
| cfg_last | input | 4 | Index of the last level |
| timing_mode | input | 1 | 1 selects timing mode |
| tmr_limit | input | 32 | Expiry limits of the two timers |
| flags | input | 6 | Recognizer match flags |
| strobe | input | 1 | Sample strobe |
| arm_run | input | 1 | Run arm request |
| arm_peer | input | 1 | Arm from partner sequencer |
| ext_arm | input | 1 | External arm line, rising edge active |
| level | output | 4 | Current sequence level |
| active | output | 1 | Sequencer armed and running |
| store_en | output | 1 | Keep the sample strobed in the previous cycle |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The hardest situation to reach from the ports is a timer-qualified advance. A level must start a timer on entry, the timer must count to its limit, and only then can its expiry flag satisfy the level's condition. Random conditions almost never line this up. A directed case therefore enters a level that starts timer 0 with a limit of 4 and waits on source 6, so the trigger cycle can be counted exactly. Random configurations with short counts, arbitrary branch targets (some beyond the last level) and mixed timer actions then run against a cycle-level model in the bench. These cover pauses, re-entries and modes.

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int NUM_LEVELS    = 12,
  parameter int TIMING_LEVELS = 10,
  parameter int NUM_FLAGS     = 6,
  parameter int CNT_W         = 20,
  parameter int TMR_W         = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_LEVELS*(3*(4+2*$clog2(NUM_FLAGS+2))+$clog2(NUM_LEVELS)+CNT_W+4)-1:0] cfg_levels,
  input  logic [$clog2(NUM_LEVELS)-1:0]        cfg_last,
  input  logic                                 timing_mode,
  input  logic [2*TMR_W-1:0]                   tmr_limit,
  input  logic [NUM_FLAGS-1:0]                 flags,
  input  logic                                 strobe,
  input  logic                                 arm_run,
  input  logic                                 arm_peer,
  input  logic                                 ext_arm,
  output logic [$clog2(NUM_LEVELS)-1:0]        level,
  output logic                                 active,
  output logic                                 store_en,
  output logic                                 trig
);
  localparam int LVL_W  = $clog2(NUM_LEVELS);
  localparam int SRC_W  = $clog2(NUM_FLAGS + 2);
  localparam int NSRC   = 1 << SRC_W;
  localparam int TERM_W = 4 + 2 * SRC_W;
  localparam int TGT_LO = 3 * TERM_W;
  localparam int CNT_LO = TGT_LO + LVL_W;
  localparam int TMR_LO = CNT_LO + CNT_W;
  localparam int LW     = TMR_LO + 4;
  localparam logic [LVL_W-1:0] MAX_S = LVL_W'(NUM_LEVELS - 1);
  localparam logic [LVL_W-1:0] MAX_T = LVL_W'(TIMING_LEVELS - 1);

  function automatic logic eval_term(input logic [TERM_W-1:0] t, input logic [NSRC-1:0] s);
    logic a, b;
    a = s[t[2*SRC_W-1:SRC_W]];
    b = s[t[SRC_W-1:0]];
    case (t[TERM_W-1 -: 4])
      4'd0: return 1'b1;
      4'd2: return a;
      4'd3: return !a;
      4'd4: return a & b;
      4'd5: return !(a & b);
      4'd6: return a | b;
      4'd7: return !(a | b);
      4'd8: return a ^ b;
      4'd9: return !(a ^ b);
      default: return 1'b0;
    endcase
  endfunction

  logic [LVL_W-1:0] lvl_q, nxt_lvl, cap, last_lvl, tgt;
  logic [CNT_W-1:0] occ_q, nxt_occ, need;
  logic             act_q, st_q, tr_q, ext_q;
  logic             fire, enter, arm_go;
  logic [1:0]       texp;
  logic [NSRC-1:0]  src;
  logic [LW-1:0]    cur_w, nxt_w;

  assign cap      = timing_mode ? MAX_T : MAX_S;
  assign last_lvl = (cfg_last > cap) ? cap : cfg_last;
  assign cur_w    = cfg_levels[int'(lvl_q)*LW +: LW];
  assign nxt_w    = cfg_levels[int'(nxt_lvl)*LW +: LW];
  assign tgt      = cur_w[TGT_LO +: LVL_W];
  assign need     = (cur_w[CNT_LO +: CNT_W] == '0) ? CNT_W'(1) : cur_w[CNT_LO +: CNT_W];
  assign arm_go   = !act_q && (arm_run || arm_peer || (ext_arm && !ext_q));

  always_comb begin
    src = '0;
    src[NUM_FLAGS-1:0] = flags;
    src[NUM_FLAGS]     = texp[0];
    src[NUM_FLAGS+1]   = texp[1];
  end

  always_comb begin
    nxt_lvl = lvl_q;
    nxt_occ = occ_q;
    enter   = 1'b0;
    fire    = 1'b0;
    if (act_q && strobe) begin
      if (eval_term(cur_w[TERM_W +: TERM_W], src)) begin
        nxt_lvl = (tgt > last_lvl) ? last_lvl : tgt;
        nxt_occ = '0;
        enter   = 1'b1;
      end else if (eval_term(cur_w[0 +: TERM_W], src)) begin
        if (occ_q + 1'b1 >= need) begin
          if (lvl_q >= last_lvl) fire = 1'b1;
          else begin
            nxt_lvl = lvl_q + 1'b1;
            nxt_occ = '0;
            enter   = 1'b1;
          end
        end else begin
          nxt_occ = occ_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    logic [TMR_W-1:0] cnt_q;
    logic             run_q;
    logic [TMR_W-1:0] lim;
    logic [1:0]       act;
    assign lim     = tmr_limit[g*TMR_W +: TMR_W];
    assign act     = nxt_w[TMR_LO + 2*g +: 2];
    assign texp[g] = (lim != '0) && (cnt_q == lim);
    always_ff @(posedge clk) begin
      if (!rst_n || arm_go) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (fire) begin
        run_q <= 1'b0;
      end else if (enter && nxt_lvl != '0 && act != 2'd0) begin
        case (act)
          2'd1: begin cnt_q <= '0; run_q <= 1'b1; end
          2'd2: run_q <= 1'b0;
          default: run_q <= 1'b1;
        endcase
      end else if (run_q && cnt_q != lim) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      occ_q <= '0;
      act_q <= 1'b0;
      st_q  <= 1'b0;
      tr_q  <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_arm;
      tr_q  <= fire;
      st_q  <= act_q && strobe && (timing_mode || eval_term(cur_w[2*TERM_W +: TERM_W], src));
      if (arm_go) begin
        act_q <= 1'b1;
        lvl_q <= '0;
        occ_q <= '0;
      end else if (fire) begin
        act_q <= 1'b0;
        lvl_q <= '0;
        occ_q <= '0;
      end else begin
        lvl_q <= nxt_lvl;
        occ_q <= nxt_occ;
      end
    end
  end

  assign level    = lvl_q;
  assign active   = act_q;
  assign store_en = st_q;
  assign trig     = tr_q;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int NUM_LEVELS    = 12,
  parameter int TIMING_LEVELS = 10,
  parameter int LVL_W         = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic             arm_run,
  input logic             arm_peer,
  input logic             ext_arm,
  input logic             timing_mode,
  input logic [LVL_W-1:0] level,
  input logic             active,
  input logic             store_en,
  input logic             trig
);
  localparam logic [LVL_W-1:0] MAX_S = LVL_W'(NUM_LEVELS - 1);
  localparam logic [LVL_W-1:0] MAX_T = LVL_W'(TIMING_LEVELS - 1);

  a_r6_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  a_r6_trig_idle: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (!active && level == '0));
  a_r7_store_active: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> $past(active));
  a_r10_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(strobe)) |-> (level == $past(level)));
  a_r10_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe) |-> (!store_en && !trig));
  a_r2_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(arm_run || arm_peer || ext_arm));
  a_r8_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (level <= (timing_mode ? MAX_T : MAX_S)));
endmodule

bind trig_seq trig_seq_chk #(
  .NUM_LEVELS(NUM_LEVELS), .TIMING_LEVELS(TIMING_LEVELS), .LVL_W($clog2(NUM_LEVELS))
) u_chk (.*);

// File: tb/trig_seq_tb.sv
`timescale 1ns/1ps
module trig_seq_tb_top;
  localparam int NL = 12;
  localparam int LW = 58;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL*LW-1:0] cfg = '0;
  logic [3:0]  cfg_last = '0;
  logic        timing_mode = 1'b0;
  logic [31:0] tmr_limit = '0;
  logic [5:0]  flags = '0;
  logic strobe = 1'b0, arm_run = 1'b0, arm_peer = 1'b0, ext_arm = 1'b0;
  logic [3:0] level;
  logic active, store_en, trig;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_levels(cfg), .cfg_last(cfg_last),
    .timing_mode(timing_mode), .tmr_limit(tmr_limit), .flags(flags),
    .strobe(strobe), .arm_run(arm_run), .arm_peer(arm_peer), .ext_arm(ext_arm),
    .level(level), .active(active), .store_en(store_en), .trig(trig)
  );

  function automatic logic [9:0] mk(int op, int a, int b);
    return {4'(op), 3'(a), 3'(b)};
  endfunction

  function automatic logic b_term(logic [9:0] t, logic [7:0] s);
    logic a, b;
    a = s[t[5:3]];
    b = s[t[2:0]];
    case (t[9:6])
      4'd0: return 1'b1;
      4'd2: return a;
      4'd3: return !a;
      4'd4: return a & b;
      4'd5: return !(a & b);
      4'd6: return a | b;
      4'd7: return !(a | b);
      4'd8: return a ^ b;
      4'd9: return !(a ^ b);
      default: return 1'b0;
    endcase
  endfunction

  task automatic set_lvl(int i, logic [9:0] adv, logic [9:0] br, logic [9:0] st,
                         int tgt, int cnt, int tmr);
    cfg[i*LW +: LW] = {4'(tmr), 20'(cnt), 4'(tgt), st, br, adv};
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cycle-level reference built from the requirements
  int  m_level, m_occ, m_tc[2];
  bit  m_active, m_store, m_trig, m_extq, m_run[2];

  always @(posedge clk) begin : model
    int last, nl, no, need, lim, act;
    bit fire, enter, arm_go;
    logic [LW-1:0] w, nw;
    logic [7:0] s;
    if (!rst_n) begin
      m_level = 0; m_occ = 0; m_active = 0; m_store = 0; m_trig = 0; m_extq = 0;
      for (int i = 0; i < 2; i++) begin m_tc[i] = 0; m_run[i] = 0; end
    end else begin
      last = timing_mode ? ((cfg_last > 9) ? 9 : int'(cfg_last))
                         : ((cfg_last > 11) ? 11 : int'(cfg_last));
      s = {2'b00, flags};
      for (int i = 0; i < 2; i++) begin
        lim = int'(tmr_limit[i*16 +: 16]);
        s[6+i] = (lim != 0) && (m_tc[i] == lim);
      end
      w = cfg[m_level*LW +: LW];
      fire = 0; enter = 0; nl = m_level; no = m_occ;
      if (m_active && strobe) begin
        if (b_term(w[19:10], s)) begin
          nl = (int'(w[33:30]) > last) ? last : int'(w[33:30]);
          no = 0; enter = 1;
        end else if (b_term(w[9:0], s)) begin
          need = (w[53:34] == 0) ? 1 : int'(w[53:34]);
          if (m_occ + 1 >= need) begin
            if (m_level >= last) fire = 1;
            else begin nl = m_level + 1; no = 0; enter = 1; end
          end else no = m_occ + 1;
        end
      end
      m_store = m_active && strobe && (timing_mode || b_term(w[29:20], s));
      arm_go = !m_active && (arm_run || arm_peer || (ext_arm && !m_extq));
      nw = cfg[nl*LW +: LW];
      for (int i = 0; i < 2; i++) begin
        lim = int'(tmr_limit[i*16 +: 16]);
        act = int'(nw[54+2*i +: 2]);
        if (arm_go) begin m_tc[i] = 0; m_run[i] = 0; end
        else if (fire) m_run[i] = 0;
        else if (enter && nl != 0 && act != 0) begin
          if (act == 1) begin m_tc[i] = 0; m_run[i] = 1; end
          else if (act == 2) m_run[i] = 0;
          else m_run[i] = 1;
        end else if (m_run[i] && m_tc[i] != lim) m_tc[i]++;
      end
      if (arm_go) begin m_active = 1; m_level = 0; m_occ = 0; end
      else if (fire) begin m_active = 0; m_level = 0; m_occ = 0; end
      else begin m_level = nl; m_occ = no; end
      m_trig = fire;
      m_extq = ext_arm;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(level == 4'(m_level), "R4", "level vs model", int'(level), m_level);
      chk(active == m_active, "R2", "active vs model", int'(active), int'(m_active));
      chk(store_en == m_store, "R7", "store_en vs model", int'(store_en), int'(m_store));
      chk(trig == m_trig, "R6", "trig vs model", int'(trig), int'(m_trig));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; strobe = 0; arm_run = 0; arm_peer = 0; ext_arm = 0; flags = '0;
    cfg = '0; timing_mode = 0; cfg_last = 0; tmr_limit = '0;
    step(2);
    rst_n = 1;
  endtask

  task automatic arm();
    arm_run = 1; step(); arm_run = 0;
  endtask

  task automatic finish_test();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic op_case(int op, int a, int b, logic [5:0] f_no, logic [5:0] f_yes);
    do_reset();
    cfg_last = 1;
    set_lvl(0, mk(op, a, b), mk(1,0,0), mk(1,0,0), 0, 1, 0);
    set_lvl(1, mk(1,0,0), mk(1,0,0), mk(1,0,0), 0, 1, 0);
    arm(); strobe = 1; flags = f_no; step();
    chk(level == 0, "R3", $sformatf("op %0d false input held", op), int'(level), 0);
    flags = f_yes; step();
    chk(level == 1, "R3", $sformatf("op %0d true input advanced", op), int'(level), 1);
    strobe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_test();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    step();
    // R1 reset state
    chk(level == 0, "R1", "level after reset", int'(level), 0);
    chk(active == 0, "R1", "active after reset", int'(active), 0);
    chk(store_en == 0, "R1", "store_en after reset", int'(store_en), 0);
    chk(trig == 0, "R1", "trig after reset", int'(trig), 0);

    // R10 strobe low holds everything
    set_lvl(0, mk(0,0,0), mk(0,0,0), mk(0,0,0), 1, 1, 0);
    cfg_last = 3;
    arm(); step(3);
    chk(active == 1 && level == 0, "R10", "level with strobe low", int'(level), 0);
    chk(store_en == 0 && trig == 0, "R10", "no store or trig with strobe low", int'(store_en), 0);

    // R5 branch priority over advance and target clamp
    do_reset();
    cfg_last = 1;
    set_lvl(0, mk(0,0,0), mk(0,0,0), mk(1,0,0), 0, 1, 0);
    set_lvl(1, mk(1,0,0), mk(1,0,0), mk(1,0,0), 0, 1, 0);
    arm(); strobe = 1; step(3);
    chk(level == 0 && active == 1, "R5", "branch to self beats advance", int'(level), 0);
    set_lvl(0, mk(0,0,0), mk(0,0,0), mk(1,0,0), 9, 1, 0);
    step();
    chk(level == 1, "R5", "target beyond last clamps", int'(level), 1);
    strobe = 0;

    // R4 R6 R7 occurrence count, trigger pulse, store condition
    do_reset();
    cfg_last = 0;
    set_lvl(0, mk(0,0,0), mk(1,0,0), mk(2,0,0), 0, 3, 0);
    arm(); strobe = 1; flags = 6'd1; step();
    chk(store_en == 1, "R7", "store condition true", int'(store_en), 1);
    chk(trig == 0, "R4", "no trig after 1 of 3", int'(trig), 0);
    flags = 6'd0; step();
    chk(store_en == 0, "R7", "store condition false", int'(store_en), 0);
    chk(trig == 0, "R4", "no trig after 2 of 3", int'(trig), 0);
    step();
    chk(trig == 1, "R6", "trig on 3rd qualified sample", int'(trig), 1);
    chk(active == 0, "R6", "idle after trigger", int'(active), 1'b0);
    strobe = 0; step();
    chk(trig == 0, "R6", "trig lasts one cycle", int'(trig), 0);

    // R2 external edge arming, held level ignored
    set_lvl(0, mk(0,0,0), mk(1,0,0), mk(1,0,0), 0, 1, 0);
    ext_arm = 1; step();
    chk(active == 1, "R2", "rising ext_arm arms", int'(active), 1);
    strobe = 1; step(); strobe = 0;
    chk(trig == 1, "R2", "armed run triggers", int'(trig), 1);
    step(2);
    chk(active == 0, "R2", "held ext_arm does not re-arm", int'(active), 0);
    ext_arm = 0; step(); ext_arm = 1; step();
    chk(active == 1, "R2", "second edge re-arms", int'(active), 1);
    ext_arm = 0;

    // R8 timing mode level cap, R7 store in timing mode
    do_reset();
    timing_mode = 1; cfg_last = 11;
    for (int i = 0; i < NL; i++) set_lvl(i, mk(0,0,0), mk(1,0,0), mk(1,0,0), 0, 1, 0);
    arm(); strobe = 1;
    for (int k = 1; k <= 9; k++) begin
      step();
      chk(level == 4'(k), "R8", "timing mode level walk", int'(level), k);
      chk(store_en == 1, "R7", "timing mode stores all", int'(store_en), 1);
    end
    step();
    chk(trig == 1, "R8", "trigger at level 9 in timing mode", int'(trig), 1);
    strobe = 0;

    // R3 operators
    op_case(8, 0, 1, 6'b000011, 6'b000001);
    op_case(5, 2, 3, 6'b001100, 6'b000100);
    op_case(7, 4, 5, 6'b010000, 6'b000000);
    op_case(3, 1, 0, 6'b000010, 6'b000000);

    // R9 timer start on entry and expiry as advance source
    do_reset();
    cfg_last = 1; tmr_limit = {16'd0, 16'd4};
    set_lvl(0, mk(0,0,0), mk(1,0,0), mk(1,0,0), 0, 1, 0);
    set_lvl(1, mk(2,6,0), mk(1,0,0), mk(1,0,0), 0, 1, 1);
    arm(); strobe = 1; step();
    chk(level == 1, "R9", "entered timer level", int'(level), 1);
    for (int k = 0; k < 4; k++) begin
      step();
      chk(trig == 0, "R9", "no trig before timer expiry", int'(trig), 0);
    end
    step();
    chk(trig == 1, "R9", "trig on timer expiry", int'(trig), 1);
    strobe = 0;

    // random configurations against the model
    do_reset();
    for (int batch = 0; batch < 40; batch++) begin
      for (int i = 0; i < NL; i++) begin
        int ops[3];
        for (int j = 0; j < 3; j++)
          ops[j] = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 1) : $urandom_range(2, 11);
        set_lvl(i, mk(ops[0], $urandom_range(0,7), $urandom_range(0,7)),
                   mk(($urandom_range(0,2) == 0) ? ops[1] : 1, $urandom_range(0,7), $urandom_range(0,7)),
                   mk(ops[2], $urandom_range(0,7), $urandom_range(0,7)),
                   $urandom_range(0, 13), $urandom_range(0, 3), $urandom_range(0, 15));
      end
      cfg_last = 4'($urandom_range(0, 13));
      timing_mode = 1'($urandom_range(0, 1));
      tmr_limit = {16'($urandom_range(0, 12)), 16'($urandom_range(0, 12))};
      for (int c = 0; c < 300; c++) begin
        flags = 6'($urandom());
        strobe = ($urandom_range(0, 3) != 0);
        arm_run = ($urandom_range(0, 30) == 0);
        arm_peer = ($urandom_range(0, 50) == 0);
        if ($urandom_range(0, 20) == 0) ext_arm = !ext_arm;
        step();
      end
    end
    finish_test();
  end
endmodule